// File: doc/BRIEF.md
# Minute Alarm Comparator

This block keeps a 24-bit alarm time-point and, once per minute, checks it against the calendar value supplied by an external time counter. The check runs a fixed number of millisecond ticks after each falling edge of the minute signal. When the two values agree, a latched match flag is set. The flag drives an output pin and stays set until the host clears it with a command.

The host talks to the block through a one-cycle command strobe with an opcode and a 24-bit data word. The commands write the alarm register, clear the match flag, and turn a no-date mode on or off. In no-date mode only the minute and hour fields take part in the comparison. The alarm register, the match flag, the no-date flag and an "undefined" status bit can be read directly on output ports. Serial bus decoding and calendar counting are handled elsewhere.

Both 24-bit words use the same packing: bits [6:0] minutes, [12:7] hours, [18:13] day and [23:19] month, every field in BCD.

Top module: `alarm_cmp`

## Requirements
- R1: After synchronous reset the match flag is 0, the alarm register is 0, the no-date flag is 0 and the undefined status bit is 1.
- R2: A command with opcode 1 loads cmd_data into the alarm register, and the new value appears on alarm_q one cycle later. Opcodes 0, 5, 6 and 7 change nothing.
- R3: A comparison strobe fires on the 4th ms_tick cycle after the cycle in which a falling edge of min_pin is detected. A tick in the cycle the edge is detected does not count. If the values agree, match_flag reads 1 from the cycle after that 4th tick; after only 3 ticks it is still 0.
- R4: In full mode all 24 bits must agree. A difference in the day or month field alone prevents a match.
- R5: When the no-date flag is 1, only bits [12:0] (minutes and hours) are compared.
- R6: The match flag stays set until an opcode 2 (clear) command. A clear in the cycle right after the flag is set takes effect.
- R7: If a clear and a successful comparison strobe occur in the same cycle, the flag ends up set.
- R8: Opcode 3 sets the no-date flag and opcode 4 clears it. Either one drops the undefined bit to 0 for good. While the undefined bit is 1, the comparison uses all 24 bits.
- R9: The match flag can only become set at a comparison strobe. Equal values, ticks or a rising min_pin edge do not set it on their own.
- R10: A new falling edge of min_pin while the count is running restarts the 4-tick count from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| min_pin | input | 1 | Minute signal; its falling edge marks a minute boundary |
| ms_tick | input | 1 | One-cycle enable at 1 kHz |
| now_val | input | 24 | Current calendar value from the time counter |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 3 | Opcode: 1 write alarm, 2 clear match, 3 set no-date, 4 clear no-date |
| cmd_data | input | 24 | Alarm value for opcode 1 |
| alarm_q | output | 24 | Alarm register contents |
| match_flag | output | 1 | Latched match flag (drives the pin) |
| nodate_flag | output | 1 | No-date mode flag |
| nodef | output | 1 | 1 until the no-date flag has first been written |

## Verification
A wrong delay count or a lost edge shows up as match_flag rising one tick early, one tick late, or not at all. A bad field mask shows up as a match, or a missing match, when only the date fields differ. Because match_flag is latched, any such error stays visible on the pin from the cycle after the strobe until the next clear. A stuck undefined bit or a stuck no-date flag shows on its port in the cycle after the command.

// File: rtl/alarm_pkg.sv
// Shared constants for the minute alarm comparator.
// Assumes 24-bit BCD packing: min[6:0], hour[12:7], day[18:13], month[23:19].
package alarm_pkg;
    localparam int STAMP_W = 24;
    localparam int HM_W    = 13;   // minutes + hours field width
    localparam int OP_W    = 3;

    typedef enum logic [OP_W-1:0] {
        OP_NONE      = 3'd0,
        OP_WR_ALARM  = 3'd1,
        OP_CLR_MATCH = 3'd2,
        OP_SET_NODT  = 3'd3,
        OP_CLR_NODT  = 3'd4
    } alarm_op_e;
endpackage

// File: rtl/alarm_delay.sv
// Minute-boundary delay: detects a falling edge on min_pin and, after
// DELAY_MS further ms_tick pulses, raises strobe for one cycle.
// Assumes min_pin is already synchronous to clk. A new falling edge
// restarts the count.
module alarm_delay #(
    parameter int DELAY_MS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic min_pin,
    input  logic ms_tick,
    output logic strobe
);
    localparam int CNT_W = $clog2(DELAY_MS + 1);

    logic             min_q;
    logic             armed;
    logic [CNT_W-1:0] cnt;
    logic             fall;

    assign fall   = min_q & ~min_pin;
    assign strobe = armed & ms_tick & (cnt == CNT_W'(DELAY_MS - 1));

    // Remember the previous level of the minute signal for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) min_q <= 1'b0;
        else        min_q <= min_pin;
    end

    // Arm on a falling edge, count ticks, disarm after the last one
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed <= 1'b0;
            cnt   <= '0;
        end else if (fall) begin
            armed <= 1'b1;
            cnt   <= '0;
        end else if (armed && ms_tick) begin
            if (strobe) armed <= 1'b0;
            else        cnt   <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/alarm_match.sv
// Masked equality of two packed time stamps. With hm_only set, only the
// low KEEP_W bits take part; otherwise all WIDTH bits are compared.
module alarm_match #(
    parameter int WIDTH  = 24,
    parameter int KEEP_W = 13
) (
    input  logic [WIDTH-1:0] a_val,
    input  logic [WIDTH-1:0] b_val,
    input  logic             hm_only,
    output logic             equal
);
    logic [WIDTH-1:0] bit_ok;

    // Per-bit agreement, forced true for date bits in hours/minutes mode
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        if (i < KEEP_W) begin : g_keep
            assign bit_ok[i] = (a_val[i] == b_val[i]);
        end else begin : g_date
            assign bit_ok[i] = (a_val[i] == b_val[i]) | hm_only;
        end
    end

    assign equal = &bit_ok;
endmodule

// File: rtl/alarm_cmp.sv
// Minute alarm comparator top. Holds the alarm register and the latched
// match flag, decodes host commands, and combines the delay strobe with
// the masked compare. A strobe with a match overrides a same-cycle clear.
module alarm_cmp
    import alarm_pkg::*;
#(
    parameter int DELAY_MS = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               min_pin,
    input  logic               ms_tick,
    input  logic [STAMP_W-1:0] now_val,
    input  logic               cmd_valid,
    input  logic [OP_W-1:0]    cmd_op,
    input  logic [STAMP_W-1:0] cmd_data,
    output logic [STAMP_W-1:0] alarm_q,
    output logic               match_flag,
    output logic               nodate_flag,
    output logic               nodef
);
    logic strobe;
    logic equal;
    logic hm_only;
    logic do_wr, do_clr, do_set_nd, do_clr_nd;

    assign do_wr     = cmd_valid && (cmd_op == OP_WR_ALARM);
    assign do_clr    = cmd_valid && (cmd_op == OP_CLR_MATCH);
    assign do_set_nd = cmd_valid && (cmd_op == OP_SET_NODT);
    assign do_clr_nd = cmd_valid && (cmd_op == OP_CLR_NODT);
    assign hm_only   = nodate_flag & ~nodef;

    alarm_delay #(.DELAY_MS(DELAY_MS)) u_delay (
        .clk     (clk),
        .rst_n   (rst_n),
        .min_pin (min_pin),
        .ms_tick (ms_tick),
        .strobe  (strobe)
    );

    alarm_match #(.WIDTH(STAMP_W), .KEEP_W(HM_W)) u_match (
        .a_val   (alarm_q),
        .b_val   (now_val),
        .hm_only (hm_only),
        .equal   (equal)
    );

    // Alarm register load
    always_ff @(posedge clk) begin
        if (!rst_n)     alarm_q <= '0;
        else if (do_wr) alarm_q <= cmd_data;
    end

    // Latched match flag: set wins over a same-cycle clear
    always_ff @(posedge clk) begin
        if (!rst_n)                match_flag <= 1'b0;
        else if (strobe && equal)  match_flag <= 1'b1;
        else if (do_clr)           match_flag <= 1'b0;
    end

    // No-date mode flag and its undefined status
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nodate_flag <= 1'b0;
            nodef       <= 1'b1;
        end else if (do_set_nd) begin
            nodate_flag <= 1'b1;
            nodef       <= 1'b0;
        end else if (do_clr_nd) begin
            nodate_flag <= 1'b0;
            nodef       <= 1'b0;
        end
    end
endmodule

// Property checker for alarm_cmp, attached by bind below.
module alarm_cmp_chk
    import alarm_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               cmd_valid,
    input logic [OP_W-1:0]    cmd_op,
    input logic [STAMP_W-1:0] cmd_data,
    input logic [STAMP_W-1:0] alarm_q,
    input logic               match_flag,
    input logic               nodef,
    input logic               strobe,
    input logic               equal
);
    // R2
    wr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == OP_WR_ALARM) |=> alarm_q == $past(cmd_data));

    // R6
    latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (match_flag && !(cmd_valid && cmd_op == OP_CLR_MATCH)) |=> match_flag);

    // R6
    clear_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == OP_CLR_MATCH && !(strobe && equal)) |=> !match_flag);

    // R7
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && equal) |=> match_flag);

    // R9
    set_only_on_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!match_flag && !(strobe && equal)) |=> !match_flag);

    // R8
    nodef_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !nodef |=> !nodef);

    // R8
    nodef_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (nodef && !(cmd_valid && (cmd_op == OP_SET_NODT || cmd_op == OP_CLR_NODT)))
        |=> nodef);
endmodule

bind alarm_cmp alarm_cmp_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_valid  (cmd_valid),
    .cmd_op     (cmd_op),
    .cmd_data   (cmd_data),
    .alarm_q    (alarm_q),
    .match_flag (match_flag),
    .nodef      (nodef),
    .strobe     (strobe),
    .equal      (equal)
);

// File: tb/alarm_cmp_bench.sv
// Bench for alarm_cmp: behavioural reference model compared every clock,
// plus directed checks per requirement.
module alarm_cmp_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        min_pin = 1'b1;
    logic        ms_tick = 1'b0;
    logic [23:0] now_val = '0;
    logic        cmd_valid = 1'b0;
    logic [2:0]  cmd_op = '0;
    logic [23:0] cmd_data = '0;
    logic [23:0] alarm_q;
    logic        match_flag, nodate_flag, nodef;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    string phase = "R1";

    always #10 clk = ~clk;

    alarm_cmp u_alarm_cmp (
        .clk(clk), .rst_n(rst_n), .min_pin(min_pin), .ms_tick(ms_tick),
        .now_val(now_val), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_data(cmd_data), .alarm_q(alarm_q), .match_flag(match_flag),
        .nodate_flag(nodate_flag), .nodef(nodef)
    );

    // Reference model state
    logic [23:0] m_alarm = '0;
    bit m_match = 0, m_nd = 0, m_undef = 1, m_prev = 0, m_wait = 0;
    int m_ticks = 0;

    always @(posedge clk) begin
        bit hit, same;
        if (!rst_n) begin
            m_alarm = '0; m_match = 0; m_nd = 0; m_undef = 1;
            m_prev = 0; m_wait = 0; m_ticks = 0;
        end else begin
            hit = m_wait && ms_tick && (m_ticks == 3);
            if (m_nd && !m_undef) same = (now_val[12:0] == m_alarm[12:0]);
            else                  same = (now_val == m_alarm);
            if (hit && same) m_match = 1;
            else if (cmd_valid && cmd_op == 3'd2) m_match = 0;
            if (m_prev && !min_pin) begin
                m_wait = 1; m_ticks = 0;
            end else if (m_wait && ms_tick) begin
                if (hit) m_wait = 0; else m_ticks++;
            end
            m_prev = min_pin;
            if (cmd_valid && cmd_op == 3'd1) m_alarm = cmd_data;
            if (cmd_valid && cmd_op == 3'd3) begin m_nd = 1; m_undef = 0; end
            if (cmd_valid && cmd_op == 3'd4) begin m_nd = 0; m_undef = 0; end
        end
    end

    task automatic check(string req, logic [23:0] act, logic [23:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Model comparison on every clock, away from the active edge
    always @(negedge clk) begin
        cycles++;
        if (rst_n) begin
            check({phase, " model alarm"}, alarm_q, m_alarm);
            check({phase, " model match"}, {23'd0, match_flag}, {23'd0, m_match});
            check({phase, " model nodate"}, {23'd0, nodate_flag}, {23'd0, m_nd});
            check({phase, " model nodef"}, {23'd0, nodef}, {23'd0, m_undef});
        end
        if (cycles > 100000) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic cmd(logic [2:0] op, logic [23:0] d);
        @(negedge clk); cmd_valid = 1; cmd_op = op; cmd_data = d;
        @(negedge clk); cmd_valid = 0; cmd_op = '0;
    endtask

    task automatic edge_fall();
        @(negedge clk); min_pin = 1;
        @(negedge clk); min_pin = 0;
        @(negedge clk);
    endtask

    task automatic ticks(int n);
        for (int i = 0; i < n; i++) begin
            ms_tick = 1; @(negedge clk); ms_tick = 0; @(negedge clk);
        end
    endtask

    localparam logic [23:0] ALM = {5'h12, 6'h25, 6'h14, 7'h30};

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1
        check("R1 match", {23'd0, match_flag}, 24'd0);
        check("R1 alarm", alarm_q, 24'd0);
        check("R1 nodef", {23'd0, nodef}, 24'd1);
        check("R1 nodate", {23'd0, nodate_flag}, 24'd0);

        phase = "R2";
        cmd(3'd1, ALM);
        check("R2 load", alarm_q, ALM);
        cmd(3'd5, 24'h0);
        cmd(3'd0, 24'h0);
        check("R2 ignored ops", alarm_q, ALM);

        phase = "R3";
        now_val = ALM;
        edge_fall();
        ticks(3);
        check("R3 after 3 ticks", {23'd0, match_flag}, 24'd0);
        ticks(1);
        check("R3 after 4th tick", {23'd0, match_flag}, 24'd1);

        phase = "R6";
        repeat (5) @(negedge clk);
        check("R6 latched", {23'd0, match_flag}, 24'd1);
        cmd(3'd2, 24'h0);
        check("R6 cleared", {23'd0, match_flag}, 24'd0);
        // clear in the cycle right after set
        edge_fall();
        ticks(3);
        ms_tick = 1; @(negedge clk); ms_tick = 0;
        cmd_valid = 1; cmd_op = 3'd2; @(negedge clk);
        cmd_valid = 0; cmd_op = '0;
        check("R6 immediate clear", {23'd0, match_flag}, 24'd0);

        phase = "R4";
        now_val = {5'h12, 6'h26, 6'h14, 7'h30};
        edge_fall(); ticks(4);
        check("R4 day differs", {23'd0, match_flag}, 24'd0);

        phase = "R8";
        check("R8 nodef before write", {23'd0, nodef}, 24'd1);
        cmd(3'd3, 24'h0);
        check("R8 nodef cleared", {23'd0, nodef}, 24'd0);
        check("R8 nodate set", {23'd0, nodate_flag}, 24'd1);

        phase = "R5";
        edge_fall(); ticks(4);
        check("R5 date ignored", {23'd0, match_flag}, 24'd1);
        cmd(3'd2, 24'h0);
        now_val = {5'h12, 6'h25, 6'h14, 7'h31};
        edge_fall(); ticks(4);
        check("R5 minute differs", {23'd0, match_flag}, 24'd0);

        phase = "R8";
        cmd(3'd4, 24'h0);
        check("R8 nodate cleared", {23'd0, nodate_flag}, 24'd0);
        check("R8 nodef stays 0", {23'd0, nodef}, 24'd0);
        now_val = {5'h11, 6'h25, 6'h14, 7'h30};
        edge_fall(); ticks(4);
        check("R4 month differs full mode", {23'd0, match_flag}, 24'd0);

        phase = "R7";
        now_val = ALM;
        edge_fall(); ticks(3);
        ms_tick = 1; cmd_valid = 1; cmd_op = 3'd2; @(negedge clk);
        ms_tick = 0; cmd_valid = 0; cmd_op = '0;
        check("R7 set beats clear", {23'd0, match_flag}, 24'd1);
        cmd(3'd2, 24'h0);

        phase = "R9";
        ticks(6);
        @(negedge clk); min_pin = 1; @(negedge clk); ticks(5);
        check("R9 no strobe no set", {23'd0, match_flag}, 24'd0);

        phase = "R10";
        edge_fall(); ticks(2);
        edge_fall(); ticks(3);
        check("R10 restarted count", {23'd0, match_flag}, 24'd0);
        ticks(1);
        check("R10 set after restart", {23'd0, match_flag}, 24'd1);

        repeat (3) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule